// File: doc/BRIEF.md
# Instruction fetch guard

The fetch guard sits on the read data path between the memory system and the CPU. It has a copy of each bus access: the address, and a flag that says whether the access is an instruction fetch or a data access. Software programs a forbidden span with a lower bound and an upper bound, then arms the guard. After that, any instruction fetch whose address falls inside the span gets a fixed trap word instead of the memory contents. The trap word is an illegal encoding, so a violation always stops the CPU. A fixed firmware RAM window is guarded at all times, whether or not the guard is armed.

Software configures the guard through a small word-addressed register port. The arm bit is sticky while the system runs application code: a write that tries to clear it is dropped. Both bounds are frozen for as long as the guard is armed. Data reads and writes are never changed. The decision is combinational on the fetch address, so a substituted word comes back in the same cycle as normal read data would.

Top module: `fetch_guard`

## Requirements
- R1: After reset the arm bit is 0 and both bounds read as 32'h0000_0000.
- R2: The register port decodes the byte offset in `cfg_off`: 0x00 is control (bit 0 is the arm bit, all other bits read 0), 0x04 is the lower bound, 0x08 is the upper bound. Any other offset reads 0. Reads return the current value combinationally while `cfg_cs` is high.
- R3: While the guard is disarmed, a fetch outside the firmware RAM window returns `mem_rdata` unchanged, even if it is inside the span.
- R4: While the guard is armed, a fetch with lower <= address <= upper returns the trap word 32'h0000_0000. Both ends are included. Addresses one below the lower bound and one above the upper bound pass unchanged.
- R5: A data access (`cpu_instr` = 0) always returns `mem_rdata` unchanged, at any address and in any state.
- R6: A fetch inside the firmware RAM window (default base 32'hD000_0000, size 32'h800, both ends included) always returns the trap word, whether or not the guard is armed.
- R7: While the guard is armed, writes to the lower and upper bound registers are ignored.
- R8: Writing 1 to control bit 0 arms the guard. Writing 0 disarms it only when `app_mode` is 0. With `app_mode` = 1, writing 0 has no effect.
- R9: A register write takes effect from the cycle after the write cycle. A fetch in the write cycle itself still sees the old configuration.
- R10: The span check uses all 32 address bits. An address that matches the span only in its low-order bits passes unchanged.
- R11: If the lower bound is above the upper bound, the span is empty and no fetch outside the firmware RAM window is trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| app_mode | input | 1 | 1 while application code runs; makes the arm bit sticky |
| cfg_cs | input | 1 | Register port select |
| cfg_we | input | 1 | Register port write strobe |
| cfg_off | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| cpu_addr | input | 32 | Address of the current CPU access |
| cpu_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| mem_rdata | input | 32 | Read data from the memory system |
| cpu_rdata | output | 32 | Read data delivered to the CPU |

## Verification
Both read paths, `cpu_rdata` and `cfg_rdata`, are due in the same cycle as the access that causes them. A register write becomes visible one clock edge later. The bench drives every access at a falling edge and pushes its expectation into a scoreboard queue. The monitor pops and compares 2 ns later, still inside that cycle and before the next rising edge. One case drives a write and an in-span fetch in the same cycle, then fetches again in the next cycle. This pins down the single edge of latency from R9.

// File: rtl/fguard_pkg.sv
`timescale 1ns/1ps
package fguard_pkg;

  // Illegal instruction encoding returned on a guarded fetch
  localparam logic [31:0] TRAP_WORD = 32'h0000_0000;

  // Register selection decoded from the byte offset
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOWER = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/fguard_regs.sv
`timescale 1ns/1ps
module fguard_regs #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             app_mode,
  input  logic             cs,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    rdata,
  output logic             armed,
  output logic [AW-1:0]    lower,
  output logic [AW-1:0]    upper
);
  import fguard_pkg::*;

  function automatic reg_sel_e sel_of(input logic [OFF_W-1:0] o);
    if (o == OFF_W'(0))      return SEL_CTRL;
    else if (o == OFF_W'(4)) return SEL_LOWER;
    else if (o == OFF_W'(8)) return SEL_UPPER;
    else                     return SEL_NONE;
  endfunction

  reg_sel_e    sel;
  logic        wr_ctrl, wr_lower, wr_upper;
  logic        arm_set, arm_clr;
  logic        armed_q;
  logic [AW-1:0] lower_q, upper_q;

  assign sel      = sel_of(off);
  assign wr_ctrl  = cs && we && (sel == SEL_CTRL);
  // bounds are frozen while armed
  assign wr_lower = cs && we && (sel == SEL_LOWER) && !armed_q;
  assign wr_upper = cs && we && (sel == SEL_UPPER) && !armed_q;
  assign arm_set  = wr_ctrl && wdata[0];
  // disarm only outside application mode
  assign arm_clr  = wr_ctrl && !wdata[0] && !app_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lower_q <= '0;
      upper_q <= '0;
    end else begin
      if (arm_set)       armed_q <= 1'b1;
      else if (arm_clr)  armed_q <= 1'b0;
      if (wr_lower) lower_q <= wdata;
      if (wr_upper) upper_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (cs) begin
      unique case (sel)
        SEL_CTRL:  rdata = {{(AW-1){1'b0}}, armed_q};
        SEL_LOWER: rdata = lower_q;
        SEL_UPPER: rdata = upper_q;
        default:   rdata = '0;
      endcase
    end
  end

  assign armed = armed_q;
  assign lower = lower_q;
  assign upper = upper_q;

  // R8: in application mode the arm bit cannot fall
  p_arm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && app_mode) |=> armed_q);

  // R7: bounds hold while armed
  p_lower_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(lower_q));
  p_upper_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(upper_q));

  // R9: a write of 1 to control arms from the next cycle
  p_arm_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && off == OFF_W'(0) && wdata[0]) |=> armed_q);

endmodule

// File: rtl/fguard_span_check.sv
`timescale 1ns/1ps
module fguard_span_check #(
  parameter int unsigned     AW      = 32,
  parameter logic [AW-1:0]   FW_BASE = 32'hD000_0000,
  parameter logic [AW-1:0]   FW_SIZE = 32'h0000_0800
) (
  input  logic          fetch,
  input  logic [AW-1:0] addr,
  input  logic          armed,
  input  logic [AW-1:0] lower,
  input  logic [AW-1:0] upper,
  output logic          span_hit,
  output logic          fw_hit,
  output logic          trap_req
);
  localparam logic [AW-1:0] FW_LAST = FW_BASE + FW_SIZE - AW'(1);

  // inclusive range test on the full address width
  function automatic logic inside_incl(input logic [AW-1:0] a,
                                       input logic [AW-1:0] lo,
                                       input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign span_hit = armed && inside_incl(addr, lower, upper);
  assign fw_hit   = inside_incl(addr, FW_BASE, FW_LAST);
  assign trap_req = fetch && (span_hit || fw_hit);

endmodule

// File: rtl/fguard_fetch_mux.sv
`timescale 1ns/1ps
module fguard_fetch_mux #(
  parameter int unsigned   DW   = 32,
  parameter logic [DW-1:0] TRAP = '0
) (
  input  logic          trap_req,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cpu_rdata
);
  assign cpu_rdata = trap_req ? TRAP : mem_rdata;
endmodule

// File: rtl/fetch_guard.sv
`timescale 1ns/1ps
module fetch_guard #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFF_W   = 8,
  parameter logic [ADDR_W-1:0] FW_BASE = 32'hD000_0000,
  parameter logic [ADDR_W-1:0] FW_SIZE = 32'h0000_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_mode,
  input  logic              cfg_cs,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_instr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam logic [DATA_W-1:0] TRAP = DATA_W'(fguard_pkg::TRAP_WORD);

  logic              armed;
  logic [ADDR_W-1:0] lower, upper;
  logic              span_hit, fw_hit, trap_req;

  fguard_regs #(.AW(ADDR_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .app_mode(app_mode),
    .cs(cfg_cs), .we(cfg_we), .off(cfg_off), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .armed(armed), .lower(lower), .upper(upper)
  );

  fguard_span_check #(.AW(ADDR_W), .FW_BASE(FW_BASE), .FW_SIZE(FW_SIZE)) u_span (
    .fetch(cpu_instr), .addr(cpu_addr), .armed(armed),
    .lower(lower), .upper(upper),
    .span_hit(span_hit), .fw_hit(fw_hit), .trap_req(trap_req)
  );

  fguard_fetch_mux #(.DW(DATA_W), .TRAP(TRAP)) u_mux (
    .trap_req(trap_req), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata)
  );

  // offset-style window test, written differently from the checker
  logic in_fw_offset;
  assign in_fw_offset = (cpu_addr - FW_BASE) < FW_SIZE;

  // R5: data accesses pass through
  p_data_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_instr |-> cpu_rdata == mem_rdata);

  // R6: firmware RAM fetches always trap
  p_fw_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_instr && in_fw_offset) |-> cpu_rdata == TRAP);

  // R3: disarmed guard leaves fetches outside the firmware window untouched
  p_disarmed_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_instr && !armed && !in_fw_offset) |-> cpu_rdata == mem_rdata);

  // R1: arm bit is low in the first cycle after reset
  p_reset_disarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !armed);

endmodule

// File: tb/fetch_guard_test.sv
`timescale 1ns/1ps
module fetch_guard_test;
  localparam logic [31:0] FWB = 32'hD000_0000;
  localparam logic [31:0] FWS = 32'h0000_0800;
  localparam logic [31:0] TRAPW = 32'h0000_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, app_mode, cfg_cs, cfg_we, cpu_instr;
  logic [7:0]  cfg_off;
  logic [31:0] cfg_wdata, cfg_rdata, cpu_addr, mem_rdata, cpu_rdata;

  fetch_guard uut (
    .clk(clk), .rst_n(rst_n), .app_mode(app_mode),
    .cfg_cs(cfg_cs), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_addr(cpu_addr), .cpu_instr(cpu_instr),
    .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata)
  );

  // scoreboard
  string       q_tag[$];
  bit          q_cpu[$];
  logic [31:0] q_exp[$];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the configuration
  bit          m_arm = 1'b0;
  logic [31:0] m_lo  = 32'h0;
  logic [31:0] m_hi  = 32'h0;

  function automatic logic [31:0] want_cpu(input logic [31:0] a, input bit ins,
                                           input logic [31:0] md);
    if (!ins) return md;
    if (a >= FWB && a <= FWB + FWS - 32'd1) return TRAPW;
    if (m_arm && a >= m_lo && a <= m_hi) return TRAPW;
    return md;
  endfunction

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return {a[15:0], 16'hBEEF};
  endfunction

  task automatic step(input bit cs, input bit we, input logic [7:0] off,
                      input logic [31:0] wd, input logic [31:0] a, input bit ins,
                      input bit chk_cfg, input logic [31:0] exp_cfg,
                      input bit chk_cpu, input string tag);
    @(negedge clk);
    cfg_cs = cs; cfg_we = we; cfg_off = off; cfg_wdata = wd;
    cpu_addr = a; cpu_instr = ins; mem_rdata = mem_of(a);
    if (chk_cfg) begin
      q_tag.push_back({tag, " cfg"}); q_cpu.push_back(1'b0); q_exp.push_back(exp_cfg);
    end
    if (chk_cpu) begin
      q_tag.push_back({tag, " cpu"}); q_cpu.push_back(1'b1);
      q_exp.push_back(want_cpu(a, ins, mem_of(a)));
    end
    if (cs && we) begin
      if (off == 8'h00) begin
        if (wd[0]) m_arm = 1'b1;
        else if (!app_mode) m_arm = 1'b0;
      end else if (off == 8'h04 && !m_arm) m_lo = wd;
      else if (off == 8'h08 && !m_arm) m_hi = wd;
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] wd);
    step(1'b1, 1'b1, off, wd, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, "");
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] e, input string tag);
    step(1'b1, 1'b0, off, 32'h0, 32'h0, 1'b0, 1'b1, e, 1'b0, tag);
  endtask

  task automatic fetch(input logic [31:0] a, input bit ins, input string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, a, ins, 1'b0, 32'h0, 1'b1, tag);
  endtask

  // monitor: compares inside the cycle, away from both edges
  initial forever begin
    @(negedge clk);
    #2;
    while (q_tag.size() > 0) begin
      string t;
      bit c;
      logic [31:0] e, got;
      t = q_tag.pop_front(); c = q_cpu.pop_front(); e = q_exp.pop_front();
      got = c ? cpu_rdata : cfg_rdata;
      total++;
      if (got !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, got, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all-reqs actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; app_mode = 1'b0; cfg_cs = 1'b0; cfg_we = 1'b0; cfg_off = 8'h0;
    cfg_wdata = 32'h0; cpu_addr = 32'h0; cpu_instr = 1'b0; mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h00, 32'h0, "R1 ctrl after reset");
    rd(8'h04, 32'h0, "R1 lower after reset");
    rd(8'h08, 32'h0, "R1 upper after reset");
    rd(8'h0C, 32'h0, "R2 unmapped offset");

    wr(8'h04, 32'h0000_1000);
    wr(8'h08, 32'h0000_1FFF);
    rd(8'h04, 32'h0000_1000, "R2 lower readback");
    rd(8'h08, 32'h0000_1FFF, "R2 upper readback");

    fetch(32'h0000_1000, 1'b1, "R3 disarmed in-span fetch");
    fetch(32'hD000_0000, 1'b1, "R6 fw base disarmed");
    fetch(32'hD000_07FF, 1'b1, "R6 fw last disarmed");
    fetch(32'hD000_0800, 1'b1, "R6 past fw window");
    fetch(32'hCFFF_FFFF, 1'b1, "R6 below fw window");
    fetch(32'hD000_0400, 1'b0, "R5 data read in fw window");

    // R9: write to arm and fetch in the same cycle, then fetch again
    step(1'b1, 1'b1, 8'h00, 32'h1, 32'h0000_1800, 1'b1, 1'b0, 32'h0, 1'b1, "R9 fetch in arm cycle");
    fetch(32'h0000_1800, 1'b1, "R9 fetch after arm");
    rd(8'h00, 32'h1, "R2 ctrl reads armed");

    fetch(32'h0000_1000, 1'b1, "R4 lower end");
    fetch(32'h0000_1FFF, 1'b1, "R4 upper end");
    fetch(32'h0000_0FFF, 1'b1, "R4 one below");
    fetch(32'h0000_2000, 1'b1, "R4 one above");
    fetch(32'h0000_1800, 1'b0, "R5 data read in span");

    wr(8'h04, 32'h0000_5000);
    wr(8'h08, 32'h0000_6000);
    rd(8'h04, 32'h0000_1000, "R7 lower locked");
    rd(8'h08, 32'h0000_1FFF, "R7 upper locked");

    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R8 firmware mode disarms");
    fetch(32'h0000_1800, 1'b1, "R8 disarmed passes");

    wr(8'h04, 32'hFFFF_FF00);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1);
    fetch(32'hFFFF_FFFF, 1'b1, "R10 top address traps");
    fetch(32'h7FFF_FF80, 1'b1, "R10 low-bit alias passes");

    app_mode = 1'b1;
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h1, "R8 app mode keeps armed");
    fetch(32'hFFFF_FF00, 1'b1, "R8 still trapping");

    app_mode = 1'b0;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0000_3000);
    wr(8'h08, 32'h0000_2000);
    wr(8'h00, 32'h1);
    fetch(32'h0000_2800, 1'b1, "R11 inverted span empty");
    fetch(32'h0000_3000, 1'b1, "R11 inverted lower passes");
    fetch(32'hD000_0010, 1'b1, "R6 fw armed");

    @(negedge clk);
    cfg_cs = 1'b0; cfg_we = 1'b0; cpu_instr = 1'b0;
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule